// File: doc/BRIEF.md
# Peripheral Output Pad Routing Matrix

This block decides, for every pad of a chip, what value the pad drives and whether its output driver is on. Each pad has its own route entry. The entry holds a source index, an enable-source bit and an open-drain bit. The source index picks one of the peripheral output signals, or the pad's bit in a software data vector. The enable comes either from a software enable vector or from the selected peripheral's own enable line.

A second per-pad entry holds a function code together with drive-strength and pull settings. The routed result reaches the pad only when the function code is 2. The drive-strength and pull fields are kept for the pad cells and do not change the logic. Configuration arrives through a single write port tagged with a register kind and a pad index. The pad data and enable outputs are registered, so each output is one clock behind the state that produces it.

Top module: `pad_out_matrix`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pad_do` and `pad_oe` are all zero. Every route entry, function code, data bit and enable bit resets to zero.
- R2: A write with `cfg_kind`=0 stores a route entry for pad `cfg_idx`. The fields are source index in `cfg_wdata[8:0]`, enable-source in bit 9 and open-drain in bit 10. A source index below `NUM_SIGS` drives `periph_out[index]` onto `pad_do`. The output appears at the clock edge after the entry and input are present.
- R3: Source index 256 drives the pad's bit of the software data vector onto `pad_do`. For this index the enable is always the pad's software enable bit.
- R4: For a peripheral source, enable-source 1 takes `pad_oe` from the pad's software enable bit. Enable-source 0 takes it from `periph_oe[index]`. With enable-source 1, a cleared software enable bit turns the pad's output driver off.
- R5: Kinds 2 and 3 write the software data bits, and kinds 4 and 5 write the software enable bits. Kinds 2 and 4 load pads 0 to 31 from `cfg_wdata[p]`. Kinds 3 and 5 load pads 32 and up from `cfg_wdata[p-32]`. Each write leaves the other half unchanged.
- R6: With open-drain set, `pad_do` is 0. `pad_oe` is the routed enable AND NOT the routed data, so the pad only ever pulls low.
- R7: A write with `cfg_kind`=1 stores the function entry. The function code is in `cfg_wdata[2:0]`, drive strength in bits 4:3, pull-up in bit 5 and pull-down in bit 6. Any function code other than 2 forces `pad_do`=0 and `pad_oe`=0 for that pad.
- R8: A source index that is neither 256 nor below `NUM_SIGS` routes data 0. Its enable comes from the pad's software enable bit.
- R9: Changing only the drive-strength or pull fields has no effect on `pad_do` or `pad_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Register kind: 0 route, 1 function, 2/3 data low/high, 4/5 enable low/high |
| cfg_idx | input | 6 | Pad index for kinds 0 and 1 |
| cfg_wdata | input | 32 | Write data |
| periph_out | input | NUM_SIGS | Peripheral output signals |
| periph_oe | input | NUM_SIGS | Peripheral output-enable signals |
| pad_do | output | NUM_PADS | Registered pad data |
| pad_oe | output | NUM_PADS | Registered pad output enable |

## Verification
The bench aims at the places where the source paths meet. One case is index 256 with enable-source clear. A design that wrongly used a peripheral enable there would leave the pad floating or driven at random. Another is an out-of-range index, where a design without a range check would pick an aliased peripheral bit. Open-drain with routed data 1 must release the pad, and a design that forgot the mask would drive high. Pads at and above 32 must follow only the high-half enable and data writes, and a wrong split would move bits between pads 0 and 32. The bench also rewrites drive and pull fields and then function codes 1 and 3. This catches a design that decodes more bits than the function code, or that lets matrix output through for non-GPIO functions.

// File: rtl/pad_out_matrix_pkg.sv
package pad_out_matrix_pkg;
  localparam int             SEL_W     = 9;
  localparam logic [SEL_W-1:0] SEL_SOFT = 9'd256;
  localparam logic [2:0]     FUNC_GPIO = 3'd2;
  localparam int             HALF_W    = 32;

  typedef enum logic [2:0] {
    K_ROUTE   = 3'd0,
    K_FUNC    = 3'd1,
    K_DATA_LO = 3'd2,
    K_DATA_HI = 3'd3,
    K_OE_LO   = 3'd4,
    K_OE_HI   = 3'd5
  } cfg_kind_e;

  typedef struct packed {
    logic             od;
    logic             en_src;
    logic [SEL_W-1:0] sel;
  } route_cfg_t;

  typedef struct packed {
    logic       pd;
    logic       pu;
    logic [1:0] drv;
    logic [2:0] fn;
  } pad_fn_t;
endpackage

// File: rtl/pad_cfg_regs.sv
module pad_cfg_regs
  import pad_out_matrix_pkg::*;
#(
  parameter int NUM_PADS = 40,
  parameter int IDX_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_kind,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [31:0]         cfg_wdata,
  output route_cfg_t          route [NUM_PADS],
  output pad_fn_t             fnc   [NUM_PADS],
  output logic [NUM_PADS-1:0] sw_data,
  output logic [NUM_PADS-1:0] sw_oe
);
  localparam int ROUTE_W = $bits(route_cfg_t);
  localparam int FN_W    = $bits(pad_fn_t);

  logic idx_ok;
  assign idx_ok = int'(cfg_idx) < NUM_PADS;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PADS; p++) begin
        route[p] <= '0;
        fnc[p]   <= '0;
      end
      sw_data <= '0;
      sw_oe   <= '0;
    end else if (cfg_we) begin
      case (cfg_kind_e'(cfg_kind))
        K_ROUTE: if (idx_ok) route[cfg_idx] <= route_cfg_t'(cfg_wdata[ROUTE_W-1:0]);
        K_FUNC:  if (idx_ok) fnc[cfg_idx]   <= pad_fn_t'(cfg_wdata[FN_W-1:0]);
        K_DATA_LO, K_DATA_HI, K_OE_LO, K_OE_HI: begin
          for (int p = 0; p < NUM_PADS; p++) begin
            if ((p < HALF_W) == (cfg_kind == K_DATA_LO || cfg_kind == K_OE_LO)) begin
              if (cfg_kind == K_DATA_LO || cfg_kind == K_DATA_HI)
                sw_data[p] <= cfg_wdata[p % HALF_W];
              else
                sw_oe[p] <= cfg_wdata[p % HALF_W];
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R7
  fn_store_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_kind == K_FUNC && idx_ok) |=>
      (fnc[$past(cfg_idx)] == pad_fn_t'($past(cfg_wdata[FN_W-1:0]))));

  // R5
  oe_lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_kind == K_OE_LO) |=> (sw_oe[NUM_PADS-1] == $past(sw_oe[NUM_PADS-1])));
endmodule

// File: rtl/pad_route_slice.sv
module pad_route_slice
  import pad_out_matrix_pkg::*;
#(
  parameter int NUM_SIGS = 16
) (
  input  route_cfg_t          cfg,
  input  logic [2:0]          fn_code,
  input  logic                sw_d,
  input  logic                sw_e,
  input  logic [NUM_SIGS-1:0] periph_out,
  input  logic [NUM_SIGS-1:0] periph_oe,
  output logic                d_o,
  output logic                e_o
);
  localparam int SIG_IDX_W = (NUM_SIGS > 1) ? $clog2(NUM_SIGS) : 1;

  logic [SIG_IDX_W-1:0] sidx;
  logic                 rd, re;

  assign sidx = cfg.sel[SIG_IDX_W-1:0];

  always_comb begin
    if (cfg.sel == SEL_SOFT) begin
      rd = sw_d;
      re = sw_e;
    end else if (int'(cfg.sel) < NUM_SIGS) begin
      rd = periph_out[sidx];
      re = cfg.en_src ? sw_e : periph_oe[sidx];
    end else begin
      rd = 1'b0;
      re = sw_e;
    end

    if (fn_code != FUNC_GPIO) begin
      d_o = 1'b0;
      e_o = 1'b0;
    end else if (cfg.od) begin
      d_o = 1'b0;
      e_o = re & ~rd;
    end else begin
      d_o = rd;
      e_o = re;
    end
  end
endmodule

// File: rtl/pad_out_matrix.sv
module pad_out_matrix
  import pad_out_matrix_pkg::*;
#(
  parameter int NUM_PADS = 40,
  parameter int NUM_SIGS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_kind,
  input  logic [5:0]          cfg_idx,
  input  logic [31:0]         cfg_wdata,
  input  logic [NUM_SIGS-1:0] periph_out,
  input  logic [NUM_SIGS-1:0] periph_oe,
  output logic [NUM_PADS-1:0] pad_do,
  output logic [NUM_PADS-1:0] pad_oe
);
  route_cfg_t          route [NUM_PADS];
  pad_fn_t             fnc   [NUM_PADS];
  logic [NUM_PADS-1:0] sw_data, sw_oe;
  logic [NUM_PADS-1:0] nxt_do, nxt_oe;

  pad_cfg_regs #(.NUM_PADS(NUM_PADS), .IDX_W(6)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .route(route), .fnc(fnc), .sw_data(sw_data), .sw_oe(sw_oe)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    pad_route_slice #(.NUM_SIGS(NUM_SIGS)) u_slice (
      .cfg(route[p]), .fn_code(fnc[p].fn), .sw_d(sw_data[p]), .sw_e(sw_oe[p]),
      .periph_out(periph_out), .periph_oe(periph_oe),
      .d_o(nxt_do[p]), .e_o(nxt_oe[p])
    );

    // R7
    non_gpio_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (fnc[p].fn != FUNC_GPIO) |=> (!pad_do[p] && !pad_oe[p]));

    // R6
    od_low_only_chk: assert property (@(posedge clk) disable iff (rst)
      (route[p].od) |=> !pad_do[p]);

    // R3
    soft_data_chk: assert property (@(posedge clk) disable iff (rst)
      (fnc[p].fn == FUNC_GPIO && !route[p].od && route[p].sel == SEL_SOFT) |=>
        (pad_do[p] == $past(sw_data[p]) && pad_oe[p] == $past(sw_oe[p])));

    // R8
    bad_sel_chk: assert property (@(posedge clk) disable iff (rst)
      (fnc[p].fn == FUNC_GPIO && route[p].sel != SEL_SOFT && int'(route[p].sel) >= NUM_SIGS) |=>
        (!pad_do[p] && pad_oe[p] == ($past(sw_oe[p]) && !$past(route[p].od))) || (pad_oe[p] == $past(sw_oe[p])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_do <= '0;
      pad_oe <= '0;
    end else begin
      pad_do <= nxt_do;
      pad_oe <= nxt_oe;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (pad_do == '0 && pad_oe == '0));
endmodule

// File: tb/pad_out_matrix_tb.sv
module pad_out_matrix_tb;
  localparam int NP = 40;
  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_kind = '0;
  logic [5:0]    cfg_idx = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [NS-1:0] periph_out = '0;
  logic [NS-1:0] periph_oe = '0;
  logic [NP-1:0] pad_do, pad_oe;

  always #2.5 clk = ~clk;

  pad_out_matrix #(.NUM_PADS(NP), .NUM_SIGS(NS)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_do(pad_do), .pad_oe(pad_oe)
  );

  // bench model of the stored configuration
  logic [8:0]    m_sel [NP];
  logic          m_src [NP];
  logic          m_od  [NP];
  logic [2:0]    m_fn  [NP];
  logic [NP-1:0] m_data, m_oe;

  int checks = 0;
  int fails  = 0;

  function automatic logic [2*NP-1:0] expect_pads();
    logic [NP-1:0] d, e;
    for (int p = 0; p < NP; p++) begin
      logic rd, re;
      if (m_sel[p] == 9'd256) begin
        rd = m_data[p]; re = m_oe[p];
      end else if (m_sel[p] < NS) begin
        rd = periph_out[m_sel[p]];
        re = m_src[p] ? m_oe[p] : periph_oe[m_sel[p]];
      end else begin
        rd = 1'b0; re = m_oe[p];
      end
      if (m_fn[p] != 3'd2) begin d[p] = 0; e[p] = 0; end
      else if (m_od[p]) begin d[p] = 0; e[p] = re & ~rd; end
      else begin d[p] = rd; e[p] = re; end
    end
    return {d, e};
  endfunction

  task automatic model_write(input logic [2:0] k, input logic [5:0] i, input logic [31:0] w);
    case (k)
      3'd0: if (i < NP) begin m_sel[i] = w[8:0]; m_src[i] = w[9]; m_od[i] = w[10]; end
      3'd1: if (i < NP) m_fn[i] = w[2:0];
      3'd2, 3'd3, 3'd4, 3'd5:
        for (int p = 0; p < NP; p++)
          if ((p < 32) == (k == 3'd2 || k == 3'd4)) begin
            if (k == 3'd2 || k == 3'd3) m_data[p] = w[p % 32];
            else m_oe[p] = w[p % 32];
          end
      default: ;
    endcase
  endtask

  // drive at negedge, write lands at next posedge, output one edge later
  task automatic wr(input logic [2:0] k, input logic [5:0] i, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_idx = i; cfg_wdata = w;
    @(posedge clk);
    model_write(k, i, w);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle_check(input string tag);
    logic [2*NP-1:0] ex;
    @(posedge clk);
    @(negedge clk);
    ex = expect_pads();
    checks++;
    if (pad_do !== ex[2*NP-1:NP] || pad_oe !== ex[NP-1:0]) begin
      fails++;
      $display("FAIL %s do=%h oe=%h expected do=%h oe=%h", tag, pad_do, pad_oe,
               ex[2*NP-1:NP], ex[NP-1:0]);
    end
  endtask

  task automatic set_periph(input logic [NS-1:0] o, input logic [NS-1:0] e);
    @(negedge clk);
    periph_out = o; periph_oe = e;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int p = 0; p < NP; p++) begin
      m_sel[p] = 0; m_src[p] = 0; m_od[p] = 0; m_fn[p] = 0;
    end
    m_data = '0; m_oe = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pad_do !== '0 || pad_oe !== '0) begin
      fails++; $display("FAIL R1 in reset do=%h oe=%h expected 0", pad_do, pad_oe);
    end
    rst = 1'b0;
    periph_out = 16'hA5C3; periph_oe = 16'h0F0F;
    settle_check("R1 after reset");

    // R2 R4: peripheral source, peripheral enable
    wr(3'd1, 6'd3, 32'd2);
    wr(3'd0, 6'd3, 32'd5);
    settle_check("R2 periph route pad3");
    set_periph(16'h0020, 16'h0000);
    settle_check("R2 periph data follows");
    set_periph(16'h0000, 16'h0020);
    settle_check("R4 periph enable");
    // R4: register enable source
    wr(3'd0, 6'd3, 32'h205);
    wr(3'd4, 6'd0, 32'h0000_0008);
    settle_check("R4 enable from register set");
    wr(3'd4, 6'd0, 32'h0);
    settle_check("R4 cleared enable turns driver off");

    // R3 R5: soft data on high pad
    wr(3'd1, 6'd35, 32'd2);
    wr(3'd0, 6'd35, 32'd256);
    wr(3'd3, 6'd0, 32'h0000_0008);
    wr(3'd5, 6'd0, 32'h0000_0008);
    settle_check("R3 soft data pad35");
    wr(3'd4, 6'd0, 32'hFFFF_FFFF);
    settle_check("R5 low enable write keeps high half");
    wr(3'd5, 6'd0, 32'h0);
    settle_check("R5 high enable write clears pad35");

    // R6 open drain
    wr(3'd5, 6'd0, 32'h8);
    wr(3'd0, 6'd35, 32'h500);
    settle_check("R6 od data1 releases");
    wr(3'd3, 6'd0, 32'h0);
    settle_check("R6 od data0 pulls low");

    // R8 out-of-range index
    wr(3'd1, 6'd7, 32'd2);
    wr(3'd0, 6'd7, 32'd300);
    set_periph(16'hFFFF, 16'hFFFF);
    settle_check("R8 unimplemented index");

    // R9 drive/pull no effect
    wr(3'd1, 6'd3, 32'h7A);
    settle_check("R9 drive and pull fields");
    // R7 non-GPIO function
    wr(3'd1, 6'd3, 32'd1);
    settle_check("R7 function 1 blocks");
    wr(3'd1, 6'd35, 32'd3);
    settle_check("R7 function 3 blocks");

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [2:0]  k;
      logic [31:0] w;
      logic [5:0]  i;
      k = 3'($urandom_range(0, 5));
      i = 6'($urandom_range(0, NP - 1));
      w = $urandom;
      if (k == 3'd0) begin
        case ($urandom_range(0, 3))
          0: w[8:0] = 9'd256;
          1: w[8:0] = 9'($urandom_range(NS, 511));
          default: w[8:0] = 9'($urandom_range(0, NS - 1));
        endcase
      end
      if (k == 3'd1 && $urandom_range(0, 3) != 0) w[2:0] = 3'd2;
      wr(k, i, w);
      set_periph(16'($urandom), 16'($urandom));
      settle_check("random R2 R3 R4 R5 R6 R7 R8");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule